// File: doc/BRIEF.md
# Flash Reset and Output Control

This block sits between the pins of a parallel NOR-style flash device and its internal command logic. It watches the active-low hardware reset pin and the active-low output-enable pin. It decides when a reset is real, and it tells the embedded program/erase engine to stop. It also keeps the command path closed and the data bus undriven until the device is ready again.

A low level on the reset pin counts as a reset only after it has lasted a minimum number of clock cycles, so short glitches are filtered out. Once a reset is accepted, the block sends a one-cycle abort to the algorithm engine and returns the device to array-read mode. It then runs an internal recovery timer. The timer is longer when a program or erase was in flight and shorter when the device was idle, and the ready/busy output is held low for the long recovery. Commands stay blocked while the pin is low, during recovery, and for a fixed delay after the pin is released. The data bus is driven only in normal operation, and only while output-enable is asserted.

Top module: `rstout_ctrl`

## Requirements
- R1: A low level on `rst_pin_n` is accepted as a reset only when the synchronized level stays low for `TRP` consecutive cycles. The pin passes through a two-flop synchronizer. A pin pulse of `TRP` cycles, driven low just after edge c, raises `abort_pulse` after edge c+TRP+2. A pulse of `TRP`-1 cycles produces no abort and leaves `cmd_accept` high.
- R2: `abort_pulse` is high for exactly one cycle for each accepted reset.
- R3: From the abort cycle until normal operation resumes, `cmd_accept`, `rd_fwd`, `wr_fwd` and `dq_oe` are all 0, whatever the command strobes and output-enable do.
- R4: If `alg_busy` is 1 in the cycle a reset is accepted, `ready` is 0 for exactly `TREADY_EMB` cycles, starting with the abort cycle, and then rises.
- R5: If `alg_busy` is 0 in the cycle a reset is accepted, `ready` stays 1 throughout. Normal operation resumes no earlier than `TREADY_IDLE`+1 cycles after the abort cycle.
- R6: Let the pin return high just after edge h, and let the reset be accepted at edge q with recovery length T. Then `cmd_accept` rises after edge max(h+3+TRH, q+T+1).
- R7: `dq_oe` is 1 only in normal operation while the synchronized `oe_pin_n` is low. A change on the pin reaches `dq_oe` two cycles later. `ready` does not depend on `oe_pin_n`.
- R8: In normal operation `ready` equals the inverse of `alg_busy`. `rd_fwd` and `wr_fwd` follow `rd_req` and `wr_req` in the same cycle.
- R9: A low level on the pin during the post-release delay puts the block back into the held state. It fires no second abort, and the post-release delay restarts from the final release.
- R10: After `por_n` is released, `cmd_accept` is 1, `abort_pulse` is 0, `dq_oe` is 0 (pins idle high) and `ready` is the inverse of `alg_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the control logic |
| rst_pin_n | input | 1 | Active-low hardware reset pin, asynchronous |
| oe_pin_n | input | 1 | Active-low output-enable pin, asynchronous |
| rd_req | input | 1 | Read command strobe |
| wr_req | input | 1 | Write command strobe |
| alg_busy | input | 1 | High while the embedded program/erase engine is running |
| dq_oe | output | 1 | Enable for the data output drivers (0 = tristate) |
| ready | output | 1 | Ready/busy pin, 1 = ready |
| abort_pulse | output | 1 | One-cycle stop request to the algorithm engine |
| cmd_accept | output | 1 | High when commands may enter the command logic |
| rd_fwd | output | 1 | Read strobe passed on through the accept gate |
| wr_fwd | output | 1 | Write strobe passed on through the accept gate |

## Verification
A wrong phase shows at the ports within a cycle, through `cmd_accept`, the gated strobes and `dq_oe`. A block stuck in a held phase keeps the gate closed, and one that returns early reopens it ahead of the computed edge. A wrong recovery count or a wrong recorded busy flag moves the rising edge of `ready` or `cmd_accept`, so the bench compares the exact cycle of every abort, ready and accept edge against edges predicted from pin timings. A wrong qualifier count shows as an abort that is missing, extra or shifted for pulses one cycle either side of the threshold.

// File: rtl/rstout_pkg.sv
package rstout_pkg;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_HOLD = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  // Recovery length chosen by the busy state sampled at qualification.
  function automatic int recovery_len(input logic emb, input int emb_len, input int idle_len);
    return emb ? emb_len : idle_len;
  endfunction

  // Post-release window reload value: the counter reaches zero TRH-1
  // cycles after loading, and the phase leaves one cycle later.
  function automatic int release_reload(input int trh);
    return (trh > 0) ? trh - 1 : 0;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstout_sync.sv
module rstout_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rstout_qual.sv
module rstout_qual #(
  parameter int TRP = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic arm,
  input  logic sig_low,
  output logic qual
);

  localparam int QW = $clog2(TRP + 1);
  localparam logic [QW-1:0] LAST = QW'(TRP - 1);

  logic [QW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt_q <= '0;
    end else if (arm && sig_low) begin
      if (low_cnt_q != LAST) low_cnt_q <= low_cnt_q + 1'b1;
    end else begin
      low_cnt_q <= '0;
    end
  end

  assign qual = arm && sig_low && (low_cnt_q == LAST);

endmodule

// File: rtl/rstout_timer.sv
module rstout_timer #(
  parameter int MAXV = 16
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        load,
  input  logic [$clog2(MAXV+1)-1:0]   load_val,
  input  logic                        en,
  output logic                        zero
);

  localparam int TW = $clog2(MAXV + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rstout_ctrl.sv
module rstout_ctrl #(
  parameter int TRP         = 4,
  parameter int TREADY_EMB  = 20,
  parameter int TREADY_IDLE = 6,
  parameter int TRH         = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic oe_pin_n,
  input  logic rd_req,
  input  logic wr_req,
  input  logic alg_busy,
  output logic dq_oe,
  output logic ready,
  output logic abort_pulse,
  output logic cmd_accept,
  output logic rd_fwd,
  output logic wr_fwd
);

  import rstout_pkg::*;

  localparam int REC_MAX = max_of(max_of(TREADY_EMB, TREADY_IDLE), 1);
  localparam int REC_W   = $clog2(REC_MAX + 1);
  localparam int RH_MAX  = max_of(TRH, 1);
  localparam int RH_W    = $clog2(RH_MAX + 1);
  localparam logic [RH_W-1:0] RH_LOAD = RH_W'(release_reload(TRH));

  // Named internal events, visible to the bound checker.
  logic   rst_sync;
  logic   oe_sync_n;
  logic   qual_evt;
  logic   rec_done;
  logic   rh_done;
  logic   in_run;
  logic   release_evt;
  logic   emb_q;
  logic   abort_q;
  phase_t phase_q, phase_d;
  logic [REC_W-1:0] rec_load_val;

  rstout_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_rst (
    .clk(clk), .por_n(por_n), .din(rst_pin_n), .dout(rst_sync)
  );

  rstout_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_oe (
    .clk(clk), .por_n(por_n), .din(oe_pin_n), .dout(oe_sync_n)
  );

  assign in_run = (phase_q == PH_RUN);

  rstout_qual #(.TRP(TRP)) u_qual (
    .clk(clk), .por_n(por_n), .arm(in_run), .sig_low(!rst_sync), .qual(qual_evt)
  );

  assign rec_load_val = REC_W'(recovery_len(alg_busy, TREADY_EMB, TREADY_IDLE));

  rstout_timer #(.MAXV(REC_MAX)) u_rec (
    .clk(clk), .por_n(por_n), .load(qual_evt), .load_val(rec_load_val),
    .en(!in_run), .zero(rec_done)
  );

  assign release_evt = (phase_q == PH_HOLD) && rst_sync;

  rstout_timer #(.MAXV(RH_MAX)) u_rh (
    .clk(clk), .por_n(por_n), .load(release_evt), .load_val(RH_LOAD),
    .en(phase_q == PH_WAIT), .zero(rh_done)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_RUN:  if (qual_evt) phase_d = PH_HOLD;
      PH_HOLD: if (rst_sync) phase_d = PH_WAIT;
      PH_WAIT: begin
        if (!rst_sync)                phase_d = PH_HOLD;
        else if (rh_done && rec_done) phase_d = PH_RUN;
      end
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_RUN;
      emb_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      abort_q <= qual_evt;
      if (qual_evt) emb_q <= alg_busy;
    end
  end

  assign abort_pulse = abort_q;
  assign cmd_accept  = in_run;
  assign rd_fwd      = rd_req && in_run;
  assign wr_fwd      = wr_req && in_run;
  assign dq_oe       = in_run && !oe_sync_n;
  assign ready       = in_run ? !alg_busy : !(emb_q && !rec_done);

endmodule

// File: rtl/rstout_ctrl_chk.sv
module rstout_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic rst_s,
  input logic oe_s_n,
  input logic alg_busy,
  input logic dq_oe,
  input logic ready,
  input logic abort_pulse,
  input logic cmd_accept,
  input logic rd_fwd,
  input logic wr_fwd
);

  p_abort_after_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    abort_pulse |-> $past(!rst_s));

  p_abort_one_cycle_r2: assert property (@(posedge clk) disable iff (!por_n)
    abort_pulse |=> !abort_pulse);

  p_gate_closed_r3: assert property (@(posedge clk) disable iff (!por_n)
    !cmd_accept |-> (!dq_oe && !rd_fwd && !wr_fwd));

  p_abort_closes_r3: assert property (@(posedge clk) disable iff (!por_n)
    abort_pulse |-> !cmd_accept);

  p_emb_busy_r4: assert property (@(posedge clk) disable iff (!por_n)
    (abort_pulse && $past(alg_busy)) |-> !ready);

  p_idle_ready_r5: assert property (@(posedge clk) disable iff (!por_n)
    (abort_pulse && !$past(alg_busy)) |-> ready);

  p_release_block_r6: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_s) && !cmd_accept) |=> !cmd_accept);

  p_oe_tristate_r7: assert property (@(posedge clk) disable iff (!por_n)
    oe_s_n |-> !dq_oe);

  p_run_ready_r8: assert property (@(posedge clk) disable iff (!por_n)
    cmd_accept |-> (ready == !alg_busy));

  p_abort_from_run_r9: assert property (@(posedge clk) disable iff (!por_n)
    abort_pulse |-> $past(cmd_accept));

endmodule

bind rstout_ctrl rstout_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_s(rst_sync), .oe_s_n(oe_sync_n),
  .alg_busy(alg_busy), .dq_oe(dq_oe), .ready(ready), .abort_pulse(abort_pulse),
  .cmd_accept(cmd_accept), .rd_fwd(rd_fwd), .wr_fwd(wr_fwd)
);

// File: tb/rstout_ctrl_test.sv
`timescale 1ns/1ps
module rstout_ctrl_test;

  localparam int TRP = 4, TEMB = 20, TIDLE = 6, TRH = 5;
  localparam int K_ABORT = 0, K_READY = 1, K_ACCEPT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, rst_pin_n = 1'b1, oe_pin_n = 1'b1;
  logic rd_req = 1'b0, wr_req = 1'b0, alg_busy = 1'b0;
  logic dq_oe, ready, abort_pulse, cmd_accept, rd_fwd, wr_fwd;

  rstout_ctrl #(.TRP(TRP), .TREADY_EMB(TEMB), .TREADY_IDLE(TIDLE), .TRH(TRH)) uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .oe_pin_n(oe_pin_n),
    .rd_req(rd_req), .wr_req(wr_req), .alg_busy(alg_busy), .dq_oe(dq_oe),
    .ready(ready), .abort_pulse(abort_pulse), .cmd_accept(cmd_accept),
    .rd_fwd(rd_fwd), .wr_fwd(wr_fwd)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;

  typedef struct {int kind; int at; string req;} ev_t;
  ev_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Scoreboard insertion, kept ordered by cycle, then by kind.
  function automatic void expect_ev(input int kind, input int at, input string req);
    int idx = exp_q.size();
    for (int i = 0; i < exp_q.size(); i++) begin
      if (exp_q[i].at > at || (exp_q[i].at == at && exp_q[i].kind > kind)) begin
        idx = i;
        break;
      end
    end
    exp_q.insert(idx, '{kind, at, req});
  endfunction

  task automatic observe(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected edge of kind", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.req, "edge kind", kind, e.kind);
      check(e.at == cyc, e.req, "edge cycle", cyc, e.at);
    end
  endtask

  // Monitor: rising edges of abort, ready and accept.
  bit mon_en = 1'b0;
  logic pa, pr, pc;
  always @(negedge clk) begin
    if (mon_en) begin
      if (abort_pulse && !pa) observe(K_ABORT);
      if (ready && !pr)       observe(K_READY);
      if (cmd_accept && !pc)  observe(K_ACCEPT);
    end
    pa = abort_pulse; pr = ready; pc = cmd_accept;
  end

  // Driver: one reset pin scenario, expectations pushed up front.
  task automatic run_pulse(input int len, input bit bounce, input bit emb, input string tag);
    int c, q, h, t, acc, stop;
    bit qualifies = (len >= TRP);
    if (emb) begin
      @(negedge clk); #1 alg_busy = 1'b1;
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    c = cyc;
    h = bounce ? c + len + 4 : c + len;
    t = emb ? TEMB : TIDLE;
    q = c + TRP + 2;
    acc = (h + 3 + TRH > q + t + 1) ? h + 3 + TRH : q + t + 1;
    if (qualifies) begin
      expect_ev(K_ABORT, q, "R1");
      expect_ev(K_ACCEPT, acc, bounce ? "R9" : (emb ? "R6" : "R5"));
      if (emb) expect_ev(K_READY, q + t, "R4");
    end
    stop = qualifies ? acc + 3 : c + len + 20;
    #1 rst_pin_n = 1'b0;
    while (cyc < stop) begin
      @(negedge clk);
      if (qualifies && cyc == q + 1) begin
        check(cmd_accept == 1'b0, "R3", {tag, " accept in reset"}, cmd_accept, 0);
        check(rd_fwd == 1'b0, "R3", {tag, " rd_fwd in reset"}, rd_fwd, 0);
        check(wr_fwd == 1'b0, "R3", {tag, " wr_fwd in reset"}, wr_fwd, 0);
        check(dq_oe == 1'b0, "R3", {tag, " dq_oe in reset"}, dq_oe, 0);
        check(ready == !emb, emb ? "R4" : "R5", {tag, " ready in recovery"}, ready, !emb);
      end
      if (!qualifies && cyc == c + len + 10)
        check(cmd_accept == 1'b1, "R1", {tag, " glitch ignored"}, cmd_accept, 1);
      if (bounce && cyc == c + len + 6)
        check(cmd_accept == 1'b0, "R9", {tag, " bounce holds gate"}, cmd_accept, 0);
      if (qualifies && cyc == acc - 1)
        check(cmd_accept == 1'b0, "R6", {tag, " gate before release"}, cmd_accept, 0);
      #1;
      if (cyc == c + len) rst_pin_n = 1'b1;
      if (bounce && cyc == c + len + 2) rst_pin_n = 1'b0;
      if (bounce && cyc == c + len + 4) rst_pin_n = 1'b1;
      if (emb && cyc == q) alg_busy = 1'b0;
    end
  endtask

  task automatic finish_run();
    while (exp_q.size() > 0) begin
      ev_t e = exp_q.pop_front();
      check(1'b0, e.req, "missing edge at cycle", -1, e.at);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    #1 por_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    // R10: state after power-on reset
    check(cmd_accept == 1'b1, "R10", "accept after por", cmd_accept, 1);
    check(abort_pulse == 1'b0, "R10", "abort after por", abort_pulse, 0);
    check(dq_oe == 1'b0, "R10", "dq_oe after por", dq_oe, 0);
    check(ready == 1'b1, "R10", "ready after por", ready, 1);

    // R8: ready follows busy, strobes pass in normal operation
    #1 alg_busy = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R8", "ready with busy", ready, 0);
    check(rd_fwd == 1'b1, "R8", "rd_fwd passes", rd_fwd, 1);
    check(wr_fwd == 1'b0, "R8", "wr_fwd idle", wr_fwd, 0);
    c = cyc;
    expect_ev(K_READY, c + 1, "R8");
    #1 alg_busy = 1'b0; rd_req = 1'b0; wr_req = 1'b1;
    @(negedge clk);
    check(wr_fwd == 1'b1, "R8", "wr_fwd passes", wr_fwd, 1);
    #1 wr_req = 1'b0;

    // R7: output-enable latency and independence of ready
    @(negedge clk);
    c = cyc;
    #1 oe_pin_n = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b0, "R7", "dq_oe one cycle after oe", dq_oe, 0);
    @(negedge clk);
    check(dq_oe == 1'b1, "R7", "dq_oe two cycles after oe", dq_oe, 1);
    check(ready == 1'b1, "R7", "ready unaffected by oe", ready, 1);
    #1 oe_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dq_oe == 1'b0, "R7", "dq_oe after oe release", dq_oe, 0);

    // Reset scenarios with commands and output-enable held active
    #1 oe_pin_n = 1'b0; rd_req = 1'b1; wr_req = 1'b1;
    run_pulse(TRP - 1, 1'b0, 1'b0, "glitch");     // R1
    run_pulse(TRP,     1'b0, 1'b0, "idle_min");   // R1 R5
    run_pulse(15,      1'b0, 1'b0, "idle_long");  // R6
    run_pulse(6,       1'b0, 1'b1, "emb");        // R4 R6
    run_pulse(8,       1'b1, 1'b0, "bounce");     // R9
    repeat (4) @(negedge clk);
    check(dq_oe == 1'b1, "R7", "dq_oe back after reset", dq_oe, 1);
    finish_run();
  end

endmodule